// File: doc/BRIEF.md
# Immediate Count Shift Unit

This block carries out a 32-bit shift of one operand by a count that comes from an 8-bit immediate byte. The shift kind comes from the 3-bit subop field of the addressing byte that follows a group shift opcode. The unit supports a left shift, a right shift that fills with zeros, and a right shift that copies the sign bit. The caller fetches the operand, presents it together with the raw count byte and the addressing byte for one cycle on `in_valid`, and takes the result and a write strobe one cycle later. Operand fetch and writeback addressing stay with the caller.

The unit keeps three condition flags of its own: sign, zero and overflow. Each shift kind updates them by its own rules. A shift whose masked count is zero writes the operand back unchanged and leaves every flag as it was. Overflow changes only on a shift by exactly one. A subop value that names no supported shift raises an error strobe instead of a write.

Top module: `shc_unit`

## Requirements
- R1: The shift kind comes from bits 5:3 of `in_modrm`: 4 selects a left shift, 5 a zero-filling right shift, and 7 a sign-copying right shift. For a legal subop sampled with `in_valid` high, `out_wr_en` is high for exactly the next cycle and `out_result` holds the shifted value.
- R2: Only bits 4:0 of `in_count` set the shift amount. Bits 7:5 have no effect, so a count byte of 0x21 shifts by 1 and 0x20 shifts by 0.
- R3: A left shift by exactly 1 sets OF to the XOR of operand bits 31 and 30. A shift of any kind by a masked count of 2 or more leaves OF unchanged.
- R4: A zero-filling right shift puts zeros in the vacated high bits and always clears SF. When the count is exactly 1, OF takes operand bit 31.
- R5: A sign-copying right shift fills the vacated high bits with operand bit 31. When the count is exactly 1, it clears OF.
- R6: After a shift with a nonzero masked count, ZF is 1 exactly when the result is zero. For the left and sign-copying kinds, SF equals result bit 31.
- R7: With a legal subop and a masked count of zero, `out_result` becomes the operand and `out_wr_en` pulses, while SF, ZF and OF keep their previous values.
- R8: Any subop other than 4, 5 or 7 pulses `out_err` for one cycle and does not raise `out_wr_en`. The result and the flags keep their previous values.
- R9: After synchronous reset, `out_result` is zero, all flags are zero, and `out_wr_en` and `out_err` are low.
- R10: A cycle without `in_valid` produces no write and no error, and it leaves the result and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request, one cycle per operation |
| in_operand | input | 32 | Value to shift |
| in_count | input | 8 | Raw immediate count byte |
| in_modrm | input | 8 | Addressing byte; bits 5:3 pick the shift kind |
| out_result | output | 32 | Registered shift result |
| out_wr_en | output | 1 | One-cycle strobe: write `out_result` back |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_of | output | 1 | Overflow flag |
| out_err | output | 1 | One-cycle strobe: illegal subop |

## Verification
The assertions check on every cycle that the write and error strobes exclude each other and appear only after a request. They also check that idle cycles, illegal subops and zero counts leave the flags alone, and that OF holds for counts of two or more. They further check that ZF tracks a zero result and that a zero-filling shift leaves SF clear. Only the bench's scenarios can show the actual shifted values: zero versus sign fill, masking of the upper count bits, the bit-31/bit-30 overflow rule, and counts at the extremes of 1 and 31.

// File: rtl/shc_pkg.sv
package shc_pkg;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int SUBOP_LO = 3;

    localparam logic [2:0] SUBOP_LEFT  = 3'd4;
    localparam logic [2:0] SUBOP_RZERO = 3'd5;
    localparam logic [2:0] SUBOP_RSIGN = 3'd7;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RZERO = 2'd1,
        SK_RSIGN = 2'd2,
        SK_NONE  = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic of;
    } shc_flags_t;

    function automatic shift_kind_e subop_to_kind(input logic [2:0] subop);
        case (subop)
            SUBOP_LEFT:  return SK_LEFT;
            SUBOP_RZERO: return SK_RZERO;
            SUBOP_RSIGN: return SK_RSIGN;
            default:     return SK_NONE;
        endcase
    endfunction
endpackage

// File: rtl/shc_decode.sv
module shc_decode
    import shc_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    output shift_kind_e       kind,
    output logic              legal
);
    logic unused_modrm_bits;
    assign unused_modrm_bits = ^{modrm[BYTE_W-1:SUBOP_LO+3], modrm[SUBOP_LO-1:0]};

    always_comb begin
        kind  = subop_to_kind(modrm[SUBOP_LO+2:SUBOP_LO]);
        legal = (kind != SK_NONE);
    end
endmodule

// File: rtl/shc_barrel.sv
module shc_barrel
    import shc_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] amount,
    input  shift_kind_e   kind,
    output logic [W-1:0]  shifted
);
    logic          fill;
    logic [W-1:0]  lstage [0:CW];
    logic [W-1:0]  rstage [0:CW];

    assign fill      = (kind == SK_RSIGN) ? operand[W-1] : 1'b0;
    assign lstage[0] = operand;
    assign rstage[0] = operand;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        localparam int SH = 1 << i;
        assign lstage[i+1] = amount[i] ? {lstage[i][W-1-SH:0], {SH{1'b0}}} : lstage[i];
        assign rstage[i+1] = amount[i] ? {{SH{fill}}, rstage[i][W-1:SH]}   : rstage[i];
    end

    assign shifted = (kind == SK_LEFT) ? lstage[CW] : rstage[CW];
endmodule

// File: rtl/shc_flags.sv
module shc_flags
    import shc_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int CW = $clog2(W)
) (
    input  shift_kind_e   kind,
    input  logic [W-1:0]  operand,
    input  logic [W-1:0]  shifted,
    input  logic [CW-1:0] amount,
    input  shc_flags_t    cur,
    output shc_flags_t    nxt
);
    logic by_one;
    assign by_one = (amount == CW'(1));

    always_comb begin
        nxt.zf = (shifted == '0);
        nxt.sf = (kind == SK_RZERO) ? 1'b0 : shifted[W-1];
        nxt.of = cur.of;
        if (by_one) begin
            case (kind)
                SK_LEFT:  nxt.of = operand[W-1] ^ operand[W-2];
                SK_RZERO: nxt.of = operand[W-1];
                SK_RSIGN: nxt.of = 1'b0;
                default:  nxt.of = cur.of;
            endcase
        end
    end
endmodule

// File: rtl/shc_unit.sv
module shc_unit
    import shc_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int CW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W-1:0]      in_operand,
    input  logic [BYTE_W-1:0] in_count,
    input  logic [BYTE_W-1:0] in_modrm,
    output logic [W-1:0]      out_result,
    output logic              out_wr_en,
    output logic              out_sf,
    output logic              out_zf,
    output logic              out_of,
    output logic              out_err
);
    shift_kind_e   kind;
    logic          legal;
    logic [CW-1:0] amount;
    logic [W-1:0]  shifted;
    shc_flags_t    flags_q, flags_d;
    logic [W-1:0]  result_q;
    logic          wr_q, err_q;
    logic          unused_count_hi;

    assign amount          = in_count[CW-1:0];
    assign unused_count_hi = ^in_count[BYTE_W-1:CW];

    shc_decode u_dec (.modrm(in_modrm), .kind(kind), .legal(legal));

    shc_barrel #(.W(W)) u_bar (
        .operand(in_operand), .amount(amount), .kind(kind), .shifted(shifted)
    );

    shc_flags #(.W(W)) u_flg (
        .kind(kind), .operand(in_operand), .shifted(shifted),
        .amount(amount), .cur(flags_q), .nxt(flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
            wr_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            wr_q  <= in_valid && legal;
            err_q <= in_valid && !legal;
            if (in_valid && legal) begin
                result_q <= (amount != '0) ? shifted : in_operand;
                if (amount != '0)
                    flags_q <= flags_d;
            end
        end
    end

    assign out_result = result_q;
    assign out_wr_en  = wr_q;
    assign out_err    = err_q;
    assign out_sf     = flags_q.sf;
    assign out_zf     = flags_q.zf;
    assign out_of     = flags_q.of;
endmodule

// File: rtl/shc_unit_chk.sv
module shc_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_operand,
    input logic [7:0]   in_count,
    input logic [7:0]   in_modrm,
    input logic [W-1:0] out_result,
    input logic         out_wr_en,
    input logic         out_sf,
    input logic         out_zf,
    input logic         out_of,
    input logic         out_err
);
    logic legal_in;
    logic [4:0] amt_in;
    assign legal_in = (in_modrm[5:3] == 3'd4) || (in_modrm[5:3] == 3'd5) || (in_modrm[5:3] == 3'd7);
    assign amt_in   = in_count[4:0];

    p_strobes_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_wr_en && out_err));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_wr_en && !out_err && $stable(out_result)
                       && $stable(out_sf) && $stable(out_zf) && $stable(out_of)));

    p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legal_in) |=> (out_err && $stable(out_result)
                                     && $stable(out_sf) && $stable(out_zf) && $stable(out_of)));

    p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in && amt_in == 5'd0) |=>
            (out_wr_en && out_result == $past(in_operand)
             && $stable(out_sf) && $stable(out_zf) && $stable(out_of)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in && amt_in > 5'd1) |=> $stable(out_of));

    p_zf_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in && amt_in != 5'd0) |=> (out_zf == (out_result == '0)));

    p_rzero_sf_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_modrm[5:3] == 3'd5 && amt_in != 5'd0) |=> !out_sf);

    p_write_after_legal_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in) |=> (out_wr_en && !out_err));
endmodule

bind shc_unit shc_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_count(in_count), .in_modrm(in_modrm), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_sf(out_sf), .out_zf(out_zf),
    .out_of(out_of), .out_err(out_err)
);

// File: tb/sim_shc_unit.sv
`timescale 1ns/1ps
module sim_shc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [7:0]  in_count = '0;
    logic [7:0]  in_modrm = '0;
    logic [31:0] out_result;
    logic        out_wr_en, out_sf, out_zf, out_of, out_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shc_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_count(in_count), .in_modrm(in_modrm), .out_result(out_result),
        .out_wr_en(out_wr_en), .out_sf(out_sf), .out_zf(out_zf),
        .out_of(out_of), .out_err(out_err)
    );

    localparam logic [7:0] M_LEFT  = 8'hE3; // subop 4
    localparam logic [7:0] M_RZERO = 8'hEB; // subop 5
    localparam logic [7:0] M_RSIGN = 8'hFB; // subop 7

    task automatic expect_all(input string req, input logic [31:0] res, input logic wr,
                              input logic er, input logic sf, input logic zf, input logic of);
        n_chk++;
        if (out_result !== res || out_wr_en !== wr || out_err !== er ||
            out_sf !== sf || out_zf !== zf || out_of !== of) begin
            n_bad++;
            $display("FAIL %s: got res=%h wr=%b err=%b sf=%b zf=%b of=%b, expected res=%h wr=%b err=%b sf=%b zf=%b of=%b",
                     req, out_result, out_wr_en, out_err, out_sf, out_zf, out_of,
                     res, wr, er, sf, zf, of);
        end
    endtask

    // drive on a falling edge, capture on the rising edge, sample on the next falling edge
    task automatic issue(input logic [31:0] op, input logic [7:0] cnt, input logic [7:0] modrm);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_count = cnt; in_modrm = modrm;
        @(negedge clk);
        in_valid = 1'b0; in_operand = 32'hDEAD_BEEF; in_count = 8'hFF; in_modrm = 8'h00;
    endtask

    task automatic t_reset;
        expect_all("R9 reset state", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_left;
        issue(32'd13, 8'd1, M_LEFT);
        expect_all("R1 R3 left 13 by 1", 32'h1A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(32'h4000_0000, 8'd1, M_LEFT);
        expect_all("R3 R6 left by 1 bits31/30 differ", 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        issue(32'hFFFF_FFFF, 8'd4, M_LEFT);
        expect_all("R3 OF held on count 4", 32'hFFFF_FFF0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        issue(32'hC000_0001, 8'h21, M_LEFT);
        expect_all("R2 count byte 0x21 acts as 1", 32'h8000_0002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_rzero;
        issue(32'hFFFF_FFFD, 8'd1, M_RZERO);
        expect_all("R4 zero-fill right of negative", 32'h7FFF_FFFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        issue(32'd1, 8'd1, M_RZERO);
        expect_all("R4 R6 zero-fill right to zero", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_rsign;
        issue(32'hFFFF_FFFD, 8'd1, M_RSIGN);
        expect_all("R5 sign-fill right of negative", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        issue(32'd26, 8'd1, M_RSIGN);
        expect_all("R5 sign-fill right of 26", 32'hD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(32'h0000_0002, 8'd31, M_LEFT);
        expect_all("R6 left by 31 to zero", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        issue(32'h8000_0000, 8'd31, M_RSIGN);
        expect_all("R5 R6 sign-fill by 31", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_zero_count;
        issue(32'h0000_0000, 8'h20, M_LEFT);
        expect_all("R7 R2 masked count zero keeps flags", 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        issue(32'h1234_5678, 8'h00, M_RZERO);
        expect_all("R7 count zero passes operand", 32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_illegal;
        issue(32'h0000_00FF, 8'd1, 8'h03);
        expect_all("R8 subop 0 illegal", 32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        issue(32'h0000_00FF, 8'd1, 8'hF3);
        expect_all("R8 subop 6 illegal", 32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        expect_all("R10 idle cycle", 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_left();
        t_rzero();
        t_rsign();
        t_zero_count();
        t_illegal();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule